// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receive Recovery

This block recovers asynchronous serial characters from a single receive line. An external divider supplies a one-clock sample strobe. The block counts strobes into bit periods: sixteen per bit in the normal rate and eight per bit in the double rate. The line first passes through a two-flop synchronizer. A falling edge seen between two consecutive strobes opens a candidate start bit. The three centre samples of that bit are then voted, and a start that votes high is dropped as a glitch. Each accepted start restarts the sample count, so the timing of every character follows its own start edge.

After the start bit, every data bit, the optional parity bit and the first stop bit take the majority value of their three centre samples. Data arrive least significant bit first, with five to nine data bits. The receiver goes back to watching for a falling edge as soon as the last centre sample of the stop bit has been voted. A new character may therefore begin before a full-length stop bit has ended. Each recovered character is presented for one clock, together with its ninth bit, a framing error flag and a parity error flag.

Top module: `uart_rx_recover`

## Requirements
- R1: A bit period spans 16 sample strobes when `dbl_speed` is 0 and 8 when it is 1. Clocks without `sample_tick` never advance the recovery.
- R2: A start candidate is a strobe that sees the line low when the previous strobe saw it high. Centre samples 8, 9 and 10 (normal) or 4, 5 and 6 (double) of the candidate are voted. If at least two of them are high, the candidate is dropped and a new high-to-low transition is needed.
- R3: Each data bit takes the value held by at least two of its three centre samples. Bits fill `rx_data` from bit 0 upward, and bits above the character length read 0.
- R4: Only the first stop bit is voted. `rx_frame_err` is 1 exactly when that vote is 0.
- R5: The receiver re-arms right after the last stop-bit vote sample (10 normal, 6 double). A low level at the very next strobe, sample 11 or 7, starts the next character.
- R6: `rx_valid` is high for exactly one clock. It rises on the clock edge that takes the strobe carrying the last stop-bit vote sample, and at no other time.
- R7: `parity_mode` selects the parity check: 0 means no parity bit, 1 means even, 2 means odd, and 3 behaves as 0. The parity bit follows the data bits. `rx_parity_err` is 1 when the voted parity bit differs from the expected one, and it is always 0 when no parity is used.
- R8: `data_bits` gives the character length. Values below 5 act as 5 and values above 9 act as 9. `rx_bit9` carries data bit 8 for 9-bit characters and is 0 for shorter ones.
- R9: After reset all outputs are 0. A line held low from reset starts no character until a strobe has seen it high.
- R10: Every accepted start restarts the sample count, so characters separated by idle gaps of any whole number of strobes are recovered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_tick | input | 1 | One-clock sample strobe from the baud divider |
| dbl_speed | input | 1 | 1 selects 8 samples per bit, 0 selects 16 |
| data_bits | input | 4 | Number of data bits per character (5 to 9, clamped) |
| parity_mode | input | 2 | 0 none, 1 even, 2 odd, 3 none |
| rxd | input | 1 | Asynchronous receive line, idle high |
| rx_valid | output | 1 | One-clock strobe marking a recovered character |
| rx_data | output | 8 | Data bits 0 to 7 of the character |
| rx_bit9 | output | 1 | Data bit 8 for 9-bit characters |
| rx_frame_err | output | 1 | First stop bit voted low |
| rx_parity_err | output | 1 | Parity bit mismatch |

## Verification
A sample count that drifts by even one strobe moves the voting window toward a bit edge. Under noisy centre or edge samples this corrupts `rx_data` within the same character. It also shifts the `rx_valid` pulse by whole sample periods, which a reference that compares every clock sees at the first stop-bit vote. A wrong re-arm point or wrong edge tracking shows up as a character that goes missing or appears without cause, within one character time of the fault. Early-start sequences and glitch sequences drive the receiver into the states where such faults appear. A wrong parity sense or a wrong character length shows up in the error flags or in the upper data bits of the next pulse.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'd0,
    PAR_EVEN = 2'd1,
    PAR_ODD  = 2'd2,
    PAR_RSVD = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  localparam logic [3:0] MIN_CHAR = 4'd5;
  localparam logic [3:0] MAX_CHAR = 4'd9;

  // two-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // character length limited to the legal range
  function automatic logic [3:0] clamp_bits(input logic [3:0] n);
    if (n < MIN_CHAR) return MIN_CHAR;
    if (n > MAX_CHAR) return MAX_CHAR;
    return n;
  endfunction

  function automatic logic par_used(input par_mode_e m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction

  // parity bit a correct sender would append; unused data bits are zero
  function automatic logic par_expect(input logic [8:0] d, input par_mode_e m);
    return (m == PAR_ODD) ? ~(^d) : (^d);
  endfunction

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_LVL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{IDLE_LVL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler import uart_rx_pkg::*; #(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8,
  parameter int CW       = $clog2(OVS_NORM + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          dbl,
  input  logic          hold,
  input  logic          line,
  output logic [CW-1:0] cnt,
  output logic          vote_ready,
  output logic          vote_val
);

  localparam logic [CW-1:0] SPB_N   = CW'(OVS_NORM);
  localparam logic [CW-1:0] SPB_D   = CW'(OVS_DBL);
  localparam logic [CW-1:0] FIRST_N = CW'(OVS_NORM / 2);
  localparam logic [CW-1:0] FIRST_D = CW'(OVS_DBL / 2);

  logic [CW-1:0] spb, first, idx;
  logic          v_a, v_b;

  // idx is the number of the sample taken at this strobe
  always_comb begin
    spb   = dbl ? SPB_D : SPB_N;
    first = dbl ? FIRST_D : FIRST_N;
    idx   = (cnt >= spb) ? CW'(1) : cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      v_a <= 1'b0;
      v_b <= 1'b0;
    end else if (tick) begin
      if (hold) begin
        cnt <= CW'(1);
      end else begin
        cnt <= idx;
        if (idx == first)          v_a <= line;
        if (idx == first + CW'(1)) v_b <= line;
      end
    end
  end

  assign vote_ready = tick & ~hold & (idx == first + CW'(2));
  assign vote_val   = maj3(v_a, v_b, line);

endmodule

// File: rtl/uart_rx_recover.sv
module uart_rx_recover import uart_rx_pkg::*; #(
  parameter int OVS_NORM    = 16,
  parameter int OVS_DBL     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sample_tick,
  input  logic       dbl_speed,
  input  logic [3:0] data_bits,
  input  logic [1:0] parity_mode,
  input  logic       rxd,
  output logic       rx_valid,
  output logic [7:0] rx_data,
  output logic       rx_bit9,
  output logic       rx_frame_err,
  output logic       rx_parity_err
);

  localparam int CW = $clog2(OVS_NORM + 1);

  logic          line_s, line_prev;
  rx_state_e     state;
  logic [3:0]    bit_idx, nbits;
  logic [8:0]    shreg;
  logic          par_bit;
  par_mode_e     pmode;
  logic [CW-1:0] samp_cnt;
  logic          vote_ready, vote_val;
  logic          in_idle, start_edge, start_ok, start_rej, data_last, stop_done;

  uart_rx_sync #(.STAGES(SYNC_STAGES), .IDLE_LVL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (rxd),
    .q     (line_s)
  );

  uart_rx_sampler #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL), .CW(CW)) u_samp (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (sample_tick),
    .dbl        (dbl_speed),
    .hold       (in_idle),
    .line       (line_s),
    .cnt        (samp_cnt),
    .vote_ready (vote_ready),
    .vote_val   (vote_val)
  );

  // named events for the checker
  assign nbits      = clamp_bits(data_bits);
  assign pmode      = par_mode_e'(parity_mode);
  assign in_idle    = (state == ST_IDLE);
  assign start_edge = sample_tick & in_idle & line_prev & ~line_s;
  assign start_ok   = vote_ready & (state == ST_START) & ~vote_val;
  assign start_rej  = vote_ready & (state == ST_START) & vote_val;
  assign data_last  = (bit_idx == nbits - 4'd1);
  assign stop_done  = vote_ready & (state == ST_STOP);

  // line level at the previous strobe, for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           line_prev <= 1'b0;
    else if (sample_tick) line_prev <= line_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
      shreg   <= '0;
      par_bit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE:  if (start_edge) state <= ST_START;
        ST_START: begin
          if (start_rej) state <= ST_IDLE;
          if (start_ok) begin
            state   <= ST_DATA;
            bit_idx <= '0;
            shreg   <= '0;
            par_bit <= 1'b0;
          end
        end
        ST_DATA: if (vote_ready) begin
          shreg   <= shreg | (9'(vote_val) << bit_idx);
          bit_idx <= bit_idx + 4'd1;
          if (data_last) state <= par_used(pmode) ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (vote_ready) begin
          par_bit <= vote_val;
          state   <= ST_STOP;
        end
        ST_STOP: if (stop_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid      <= 1'b0;
      rx_data       <= '0;
      rx_bit9       <= 1'b0;
      rx_frame_err  <= 1'b0;
      rx_parity_err <= 1'b0;
    end else begin
      rx_valid <= stop_done;
      if (stop_done) begin
        rx_data       <= shreg[7:0];
        rx_bit9       <= shreg[8];
        rx_frame_err  <= ~vote_val;
        rx_parity_err <= par_used(pmode) & (par_bit != par_expect(shreg, pmode));
      end
    end
  end

endmodule

// File: rtl/uart_rx_recover_chk.sv
module uart_rx_recover_chk import uart_rx_pkg::*; #(
  parameter int OVS_NORM = 16,
  parameter int OVS_DBL  = 8,
  parameter int CW       = $clog2(OVS_NORM + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_tick,
  input logic          dbl_speed,
  input logic [3:0]    data_bits,
  input logic [1:0]    parity_mode,
  input logic          rx_valid,
  input logic [7:0]    rx_data,
  input logic          rx_bit9,
  input logic          rx_parity_err,
  input logic [CW-1:0] samp_cnt,
  input logic          stop_done,
  input logic          in_idle
);

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    samp_cnt <= (dbl_speed ? CW'(OVS_DBL) : CW'(OVS_NORM)));

  assert_cnt_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> $stable(samp_cnt));

  assert_one_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_valid_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(stop_done));

  assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> in_idle);

  assert_no_parity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && (parity_mode == PAR_NONE || parity_mode == PAR_RSVD)) |-> !rx_parity_err);

  assert_bit9_short_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && data_bits < 4'd9) |-> !rx_bit9);

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && data_bits >= 4'd5 && data_bits <= 4'd7) |-> ((rx_data >> data_bits) == 8'd0));

endmodule

bind uart_rx_recover uart_rx_recover_chk #(.OVS_NORM(OVS_NORM), .OVS_DBL(OVS_DBL)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sample_tick   (sample_tick),
  .dbl_speed     (dbl_speed),
  .data_bits     (data_bits),
  .parity_mode   (parity_mode),
  .rx_valid      (rx_valid),
  .rx_data       (rx_data),
  .rx_bit9       (rx_bit9),
  .rx_parity_err (rx_parity_err),
  .samp_cnt      (samp_cnt),
  .stop_done     (stop_done),
  .in_idle       (in_idle)
);

// File: tb/uart_rx_recover_test.sv
module uart_rx_recover_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_tick = 1'b0;
  logic       dbl_speed = 1'b0;
  logic [3:0] data_bits = 4'd8;
  logic [1:0] parity_mode = 2'd0;
  logic       rxd = 1'b0;
  logic       rx_valid, rx_bit9, rx_frame_err, rx_parity_err;
  logic [7:0] rx_data;

  int n_cmp = 0;
  int n_bad = 0;
  string cur_req = "R9";

  // reference model state
  int S = 16;
  int F = 8;
  bit m_prev = 1'b0;
  bit m_busy = 1'b0;
  int m_pos = 0;
  int m_word = 0;
  bit m_pbit = 1'b0;
  bit m_s[3];
  bit exp_v, exp_b9, exp_fe, exp_pe;
  int exp_data;

  always #4 clk = ~clk;  // 125 MHz

  uart_rx_recover uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .sample_tick   (sample_tick),
    .dbl_speed     (dbl_speed),
    .data_bits     (data_bits),
    .parity_mode   (parity_mode),
    .rxd           (rxd),
    .rx_valid      (rx_valid),
    .rx_data       (rx_data),
    .rx_bit9       (rx_bit9),
    .rx_frame_err  (rx_frame_err),
    .rx_parity_err (rx_parity_err)
  );

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  function automatic void cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endfunction

  function automatic int clamp_nd(int n);
    if (n < 5) return 5;
    if (n > 9) return 9;
    return n;
  endfunction

  function automatic void set_speed(bit d);
    dbl_speed = d;
    S = d ? 8 : 16;
    F = S / 2;
  endfunction

  // behavioural reference: position counted from the start edge
  task automatic model_step(input bit lvl);
    int sib, bitn, nd, ones;
    bit v, pen;
    exp_v = 1'b0;
    nd  = clamp_nd(int'(data_bits));
    pen = (parity_mode == 2'd1) || (parity_mode == 2'd2);
    if (!m_busy) begin
      if (m_prev && !lvl) begin
        m_busy = 1'b1; m_pos = 0; m_word = 0; m_pbit = 1'b0;
      end
    end else begin
      m_pos++;
    end
    if (m_busy) begin
      sib  = m_pos % S + 1;
      bitn = m_pos / S;
      if (sib >= F && sib <= F + 2) m_s[sib - F] = lvl;
      if (sib == F + 2) begin
        v = (int'(m_s[0]) + int'(m_s[1]) + int'(m_s[2])) >= 2;
        if (bitn == 0) begin
          if (v) m_busy = 1'b0;
        end else if (bitn <= nd) begin
          m_word = m_word | (int'(v) << (bitn - 1));
        end else if (pen && bitn == nd + 1) begin
          m_pbit = v;
        end else begin
          ones     = $countones(m_word);
          exp_v    = 1'b1;
          exp_data = m_word & 8'hFF;
          exp_b9   = ((m_word >> 8) & 1) != 0;
          exp_fe   = !v;
          exp_pe   = pen && (m_pbit != ((ones % 2 == 1) ^ (parity_mode == 2'd2)));
          m_busy   = 1'b0;
        end
      end
    end
    m_prev = lvl;
  endtask

  // one sample period: four clocks, strobe in the last
  task automatic drive_sample(input bit lvl);
    @(negedge clk); rxd = lvl; sample_tick = 1'b0;
    cmp(cur_req, "rx_valid idle", 16'(rx_valid), 16'd0);
    @(negedge clk);
    cmp(cur_req, "rx_valid idle", 16'(rx_valid), 16'd0);
    @(negedge clk);
    cmp(cur_req, "rx_valid idle", 16'(rx_valid), 16'd0);
    sample_tick = 1'b1;
    @(negedge clk);
    sample_tick = 1'b0;
    model_step(lvl);
    cmp(cur_req, "rx_valid", 16'(rx_valid), 16'(exp_v));
    if (exp_v) begin
      cmp("R3", "rx_data", 16'(rx_data), 16'(exp_data));
      cmp("R8", "rx_bit9", 16'(rx_bit9), 16'(exp_b9));
      cmp("R4", "rx_frame_err", 16'(rx_frame_err), 16'(exp_fe));
      cmp("R7", "rx_parity_err", 16'(rx_parity_err), 16'(exp_pe));
    end
  endtask

  task automatic idle_line(input int n);
    for (int k = 0; k < n; k++) drive_sample(1'b1);
  endtask

  task automatic send_frame(input int data, input bit par_flip, input bit stop_lvl,
                            input int stop_len, input bit noisy, input int gap);
    int nd;
    bit pb;
    nd = clamp_nd(int'(data_bits));
    for (int k = 0; k < S; k++) drive_sample(1'b0);
    for (int b = 0; b < nd; b++) begin
      bit lvl;
      lvl = data[b];
      for (int k = 0; k < S; k++) drive_sample((noisy && (k == F || k == 1)) ? ~lvl : lvl);
    end
    if (parity_mode == 2'd1 || parity_mode == 2'd2) begin
      pb = 1'b0;
      for (int b = 0; b < nd; b++) pb = pb ^ data[b];
      if (parity_mode == 2'd2) pb = ~pb;
      pb = pb ^ par_flip;
      for (int k = 0; k < S; k++) drive_sample(pb);
    end
    for (int k = 0; k < stop_len; k++) drive_sample(stop_lvl);
    idle_line(gap);
  endtask

  task automatic glitch(input int low_len);
    for (int k = 0; k < low_len; k++) drive_sample(1'b0);
    idle_line(S);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R6 watchdog expired: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    set_speed(1'b0);
    repeat (5) @(negedge clk);
    cmp("R9", "rx_valid reset", 16'(rx_valid), 16'd0);
    cmp("R9", "rx_data reset", 16'(rx_data), 16'd0);
    cmp("R9", "flags reset", {13'd0, rx_bit9, rx_frame_err, rx_parity_err}, 16'd0);
    rst_n = 1'b1;
    // line low from reset: no start until a high level is seen
    cur_req = "R9";
    for (int k = 0; k < 20; k++) drive_sample(1'b0);
    idle_line(4);

    cur_req = "R1";
    send_frame(8'hA5, 1'b0, 1'b1, S, 1'b0, 3);
    send_frame(8'h3C, 1'b0, 1'b1, S, 1'b0, 3);
    send_frame(8'h00, 1'b0, 1'b1, S, 1'b0, 3);
    send_frame(8'hFF, 1'b0, 1'b1, S, 1'b0, 3);

    cur_req = "R2";
    glitch(3);
    glitch(8);
    glitch(F);
    send_frame(8'h81, 1'b0, 1'b1, S, 1'b0, 2);

    cur_req = "R3";
    send_frame(8'h96, 1'b0, 1'b1, S, 1'b1, 2);
    send_frame(8'h4B, 1'b0, 1'b1, S, 1'b1, 2);

    cur_req = "R4";
    send_frame(8'h5A, 1'b0, 1'b0, S, 1'b0, 4);
    send_frame(8'h11, 1'b0, 1'b1, F + 2, 1'b0, 4);

    cur_req = "R5";
    send_frame(8'hC3, 1'b0, 1'b1, F + 2, 1'b0, 0);
    send_frame(8'h7E, 1'b0, 1'b1, F + 2, 1'b0, 0);
    send_frame(8'h24, 1'b0, 1'b1, F + 2, 1'b0, 2);

    cur_req = "R7";
    parity_mode = 2'd1;
    send_frame(8'h37, 1'b0, 1'b1, S, 1'b0, 2);
    send_frame(8'h37, 1'b1, 1'b1, S, 1'b0, 2);
    parity_mode = 2'd2;
    send_frame(8'hE1, 1'b0, 1'b1, S, 1'b0, 2);
    send_frame(8'hE1, 1'b1, 1'b1, S, 1'b0, 2);
    parity_mode = 2'd3;
    send_frame(8'h69, 1'b0, 1'b1, S, 1'b0, 2);
    parity_mode = 2'd0;

    cur_req = "R8";
    data_bits = 4'd9;
    send_frame(9'h1A5, 1'b0, 1'b1, S, 1'b0, 2);
    send_frame(9'h0F0, 1'b0, 1'b1, S, 1'b0, 2);
    data_bits = 4'd5;
    send_frame(8'hF5, 1'b0, 1'b1, S, 1'b0, 2);
    data_bits = 4'd12;
    parity_mode = 2'd1;
    send_frame(9'h155, 1'b0, 1'b1, S, 1'b0, 2);
    data_bits = 4'd2;
    send_frame(8'hFF, 1'b0, 1'b1, S, 1'b0, 2);
    parity_mode = 2'd0;
    data_bits = 4'd7;
    send_frame(8'hFF, 1'b0, 1'b1, S, 1'b0, 2);
    data_bits = 4'd8;

    cur_req = "R10";
    send_frame(8'h12, 1'b0, 1'b1, S, 1'b0, 1);
    send_frame(8'h34, 1'b0, 1'b1, S, 1'b0, 5);
    send_frame(8'h56, 1'b0, 1'b1, S, 1'b0, 13);

    // double speed pass
    set_speed(1'b1);
    idle_line(3);
    cur_req = "R1";
    send_frame(8'hA5, 1'b0, 1'b1, S, 1'b0, 2);
    send_frame(8'h6D, 1'b0, 1'b1, S, 1'b1, 2);
    cur_req = "R2";
    glitch(2);
    glitch(4);
    cur_req = "R5";
    send_frame(8'h9C, 1'b0, 1'b1, F + 2, 1'b0, 0);
    send_frame(8'h03, 1'b0, 1'b0, S, 1'b0, 0);
    idle_line(2);
    cur_req = "R7";
    parity_mode = 2'd2;
    send_frame(8'hB2, 1'b1, 1'b1, S, 1'b0, 2);
    parity_mode = 2'd0;
    cur_req = "R8";
    data_bits = 4'd9;
    send_frame(9'h101, 1'b0, 1'b1, F + 2, 1'b0, 3);
    data_bits = 4'd8;
    idle_line(4);

    summary();
    $finish;
  end

endmodule